// File: doc/BRIEF.md
# Self-Timed Word Programming Controller

This block sits behind the serial command front end of a small word-organised non-volatile store. When the front end has shifted in a complete write (address plus a 16-bit word, ending on the clock that carries the final data bit), it pulses a start strobe. The block then runs a programming interval whose length is a parameter counted in system-clock ticks. It holds a ready/busy output low for that whole interval and commits the word to the array when the interval ends. While the interval runs, no new command is taken.

A write-control input lets the host cancel a pending write or abort a running one. If it is high when the start strobe arrives, nothing happens. If it goes high during the interval, the interval stops at once, the target word is overwritten with all ones so that the loss can be seen, and a sticky abort flag is raised. The next accepted command clears that flag. After a write, the host can also read the ready/busy state on the serial data output by dropping the active-low select while the serial clock is low. Raising the select once the device is ready returns the status logic to idle.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: After reset, ready is 1, the data-output enable is 0, the abort flag is 0 and every array word reads 0.
- R2: An accepted start strobe (ready 1, write-control 0) makes ready read 0 from the next cycle for exactly PROG_TICKS cycles, then 1.
- R3: While ready is 0 the array still returns the old word at the target address. The new word reads back from the cycle in which ready returns to 1.
- R4: While ready is 0, cmdAccept stays 0 for any cmdReq, and a second start strobe is ignored: neither its address nor its data changes any word.
- R5: Toggling csN while ready is 0 neither shortens nor extends the programming interval.
- R6: A start strobe taken with write-control 1 is cancelled. Ready stays 1, the target word is unchanged and the abort flag stays 0.
- R7: Write-control 1, sampled at any cycle in which ready is 0, aborts the interval. In the next cycle ready is 1, the abort flag is 1 and the target word reads 16'hFFFF.
- R8: The abort flag stays 1 until an accepted command (cmdReq with ready 1, giving cmdAccept 1) and reads 0 in the following cycle.
- R9: After an accepted write, a csN falling edge sampled with sk 0 sets doOe to 1 in the next cycle, and doBit then equals ready. A csN falling edge sampled with sk 1 leaves doOe at 0.
- R10: A csN rising edge clears doOe in the next cycle. If ready is 1 at that edge, a later csN fall with sk 0 no longer drives the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Strobe: last data bit of a write has been clocked in |
| wrAddr | input | ADDR_W | Target word address of the write |
| wrData | input | DATA_W | Word to program |
| cmdReq | input | 1 | Front end asks to start any other command |
| cmdAccept | output | 1 | Command taken (high only while ready) |
| csN | input | 1 | Active-low chip select, synchronised |
| sk | input | 1 | Serial clock level, synchronised |
| wc | input | 1 | Write control: cancel or abort when high |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | DATA_W | Array word at rdAddr |
| ready | output | 1 | 1 = idle, 0 = programming |
| doOe | output | 1 | Status is being driven on the serial data output |
| doBit | output | 1 | Serial data output value (ready while doOe) |
| abortFlag | output | 1 | Sticky: last programming interval was aborted |

## Verification
Ready falls in the cycle after the edge that samples an accepted start strobe and rises PROG_TICKS edges later, in the same edge that writes the array. The read-back therefore changes together with ready. Abort and cancel take effect at the next edge, and so do the doOe set and clear that follow a csN edge. The bench drives and samples one time unit after each rising edge, so every value it reads already reflects the edge that is due to change it. The sweeps count busy cycles for every address and abort at every offset inside the interval.

// File: rtl/wcyc_pkg.sv
package wcyc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture address and word of an accepted write
    logic commit;   // program the captured word
    logic corrupt;  // abort: program the all-ones pattern
  } wstrobe_t;
endpackage

// File: rtl/prog_cycle_fsm.sv
module prog_cycle_fsm
  import wcyc_pkg::*;
#(
  parameter int PROG_TICKS = 10000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrStart,
  input  logic     cmdReq,
  input  logic     csN,
  input  logic     sk,
  input  logic     wc,
  output logic     cmdAccept,
  output logic     ready,
  output logic     doOe,
  output logic     doBit,
  output logic     abortFlag,
  output wstrobe_t stb
);
  localparam int CNT_W = $clog2(PROG_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_TICKS - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             csPrev;
  logic             armed;
  logic             wrGo;
  logic             csFall;
  logic             csRise;

  assign wrGo      = wrStart && !busy && !wc;
  assign cmdAccept = cmdReq && !busy;
  assign csFall    = csPrev && !csN;
  assign csRise    = !csPrev && csN;
  assign ready     = !busy;
  assign doBit     = doOe && ready;

  assign stb.latch   = wrGo;
  assign stb.commit  = busy && !wc && (cnt == '0);
  assign stb.corrupt = busy && wc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      csPrev    <= 1'b1;
      armed     <= 1'b0;
      doOe      <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      csPrev <= csN;
      if (busy) begin
        if (wc) begin
          busy      <= 1'b0;
          abortFlag <= 1'b1;
        end else if (cnt == '0) begin
          busy <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (wrGo) begin
          busy <= 1'b1;
          cnt  <= CNT_LOAD;
        end
        if (wrGo || cmdAccept) abortFlag <= 1'b0;
      end
      if (wrGo) armed <= 1'b1;
      else if (csRise && !busy) armed <= 1'b0;
      if (csRise) doOe <= 1'b0;
      else if (csFall && !sk && armed) doOe <= 1'b1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrStart && ready && !wc |=> !ready); // R2
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy && !wc && (cnt != '0) |=> busy); // R5
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    ready && wrStart && wc |=> ready); // R6
  AST_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    busy && wc |=> ready && abortFlag); // R7
  AST_STATUS_SK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doOe) |-> $past(!sk)); // R9
  AST_STATUS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> !doOe); // R10
endmodule

// File: rtl/prog_cycle_store.sv
module prog_cycle_store
  import wcyc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wstrobe_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (stb.latch) begin
      latAddr <= wrAddr;
      latData <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.corrupt) begin
      mem[latAddr] <= '1;
    end else if (stb.commit) begin
      mem[latAddr] <= latData;
    end
  end

  assign rdData = mem[rdAddr];

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.commit, stb.corrupt})); // R7
  AST_NO_LATCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> !stb.latch); // R4
  AST_COMMIT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> mem[$past(latAddr)] == $past(latData)); // R3
endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl
  import wcyc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int PROG_TICKS = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cmdReq,
  output logic              cmdAccept,
  input  logic              csN,
  input  logic              sk,
  input  logic              wc,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              ready,
  output logic              doOe,
  output logic              doBit,
  output logic              abortFlag
);
  wstrobe_t stb;

  prog_cycle_fsm #(.PROG_TICKS(PROG_TICKS)) uFsm (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .cmdReq(cmdReq),
    .csN(csN), .sk(sk), .wc(wc), .cmdAccept(cmdAccept), .ready(ready),
    .doOe(doOe), .doBit(doBit), .abortFlag(abortFlag), .stb(stb)
  );

  prog_cycle_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uStore (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/prog_cycle_ctrl_test.sv
`timescale 1ns/1ps
module prog_cycle_ctrl_test;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int PT = 5;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStart = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic cmdReq = 1'b0;
  logic cmdAccept;
  logic csN = 1'b1;
  logic sk = 1'b1;
  logic wc = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic ready, doOe, doBit, abortFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [DW-1:0] model [NW];

  always #2.5 clk = ~clk;

  prog_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_TICKS(PT)) uut (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrAddr(wrAddr),
    .wrData(wrData), .cmdReq(cmdReq), .cmdAccept(cmdAccept), .csN(csN),
    .sk(sk), .wc(wc), .rdAddr(rdAddr), .rdData(rdData), .ready(ready),
    .doOe(doOe), .doBit(doBit), .abortFlag(abortFlag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkRead(input int a, input logic [DW-1:0] exp, input string req);
    rdAddr = AW'(a);
    #0.1;
    chk(rdData == exp, req, rdData, exp);
  endtask

  task automatic startWrite(input int a, input logic [DW-1:0] d, input logic wcv);
    wrAddr = AW'(a); wrData = d; wrStart = 1'b1; wc = wcv;
    step();
    wrStart = 1'b0; wc = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(doOe == 1'b0, "R1 doOe", doOe, 0);
    chk(abortFlag == 1'b0, "R1 abortFlag", abortFlag, 0);
    for (int i = 0; i < NW; i++) chkRead(i, '0, "R1 array");

    // R2 R3 R4 R5 sweep over every address
    for (int a = 0; a < NW; a++) begin
      logic [DW-1:0] d;
      int busyCnt;
      d = 16'hA5C3 ^ DW'(a * 16'h1111);
      startWrite(a, d, 1'b0);
      busyCnt = 0;
      for (int k = 0; k < PT; k++) begin
        if (ready == 1'b0) busyCnt++;
        chkRead(a, model[a], "R3 old word while busy");
        wrStart = (k == 1);
        wrAddr = AW'((a + 1) % NW);
        wrData = ~d;
        csN = k[0];
        cmdReq = 1'b1;
        #0.1;
        chk(cmdAccept == 1'b0, "R4 cmdAccept while busy", cmdAccept, 0);
        step();
        cmdReq = 1'b0;
      end
      wrStart = 1'b0;
      csN = 1'b1;
      chk(busyCnt == PT, "R2 busy length", busyCnt, PT);
      chk(ready == 1'b1, "R2 ready after interval", ready, 1);
      chkRead(a, d, "R3 new word visible");
      model[a] = d;
      chkRead((a + 1) % NW, model[(a + 1) % NW], "R4 ignored strobe");
      step();
    end

    // R6 cancel at start
    startWrite(2, 16'h1357, 1'b1);
    chk(ready == 1'b1, "R6 ready", ready, 1);
    chk(abortFlag == 1'b0, "R6 abortFlag", abortFlag, 0);
    chkRead(2, model[2], "R6 word unchanged");
    step();
    chk(ready == 1'b1, "R6 ready later", ready, 1);

    // R7 R8 abort at every offset in the interval
    for (int j = 0; j < PT; j++) begin
      startWrite(j, 16'h1234 + DW'(j), 1'b0);
      repeat (j) step();
      wc = 1'b1;
      step();
      wc = 1'b0;
      chk(ready == 1'b1, "R7 ready after abort", ready, 1);
      chk(abortFlag == 1'b1, "R7 abortFlag", abortFlag, 1);
      chkRead(j, 16'hFFFF, "R7 corrupt word");
      model[j] = 16'hFFFF;
      step();
      chk(abortFlag == 1'b1, "R8 flag sticky", abortFlag, 1);
      cmdReq = 1'b1;
      #0.1;
      chk(cmdAccept == 1'b1, "R8 cmdAccept", cmdAccept, 1);
      step();
      cmdReq = 1'b0;
      chk(abortFlag == 1'b0, "R8 flag cleared", abortFlag, 0);
    end

    // R9 R10 status on data output
    csN = 1'b1; sk = 1'b1;
    step();
    startWrite(6, 16'h0F0F, 1'b0);
    csN = 1'b0; sk = 1'b1;
    step();
    chk(doOe == 1'b0, "R9 no drive with sk high", doOe, 0);
    csN = 1'b1;
    step();
    csN = 1'b0; sk = 1'b0;
    step();
    chk(doOe == 1'b1, "R9 doOe busy", doOe, 1);
    chk(doBit == 1'b0, "R9 doBit busy", doBit, 0);
    chk(ready == 1'b0, "R5 still busy", ready, 0);
    step();
    step();
    chk(ready == 1'b1, "R5 interval length kept", ready, 1);
    chk(doOe == 1'b1, "R9 doOe ready", doOe, 1);
    chk(doBit == 1'b1, "R9 doBit ready", doBit, 1);
    chkRead(6, 16'h0F0F, "R3 word after status");
    csN = 1'b1;
    step();
    chk(doOe == 1'b0, "R10 release", doOe, 0);
    csN = 1'b0; sk = 1'b0;
    step();
    step();
    chk(doOe == 1'b0, "R10 disarmed", doOe, 0);
    csN = 1'b1; sk = 1'b1;
    step();
    finish();
  end
endmodule